// File: doc/BRIEF.md
# Conditional Store/Recall Sequencer

This block decides when a volatile SRAM array is copied into its nonvolatile shadow and when the shadow is copied back. It keeps a dirty flag that records whether any SRAM write has been accepted since the last completed transfer. A store only reaches the array when that flag is set. A store can be asked for in three ways: an external active-low request line, a one-cycle software command, or a supply-low indication while automatic storing is enabled. When the supply comes back, a recall always follows.

The request line is shared. The block pulls it low as a busy indication while any store runs. After a store started by the line or by software, it drives the line high for a short time and then lets it go to the weak pull-up. Memory access is then held closed for a further guard interval. The block also gates read and write access and applies a write-protect input. The array, the supply sensing and the bus interface lie outside the block: the array reports each finished transfer with a one-cycle done strobe. All waiting times are parameters counted in clock cycles.

Top module: `nv_xfer_seq`

## Requirements
- R1: During and right after reset, access is closed, the line is released (`bsy_oe`=0), the dirty flag is 0 and no transfer start is pulsed.
- R2: While the block is powered down and `pwr_ok` is high, `arr_recall_go` pulses one cycle later without any condition. Access stays closed until `arr_done` comes back, and opens on the next cycle.
- R3: A write is accepted only while access is open. Each accepted read or write gives a one-cycle `rd_ack`/`wr_ack` together with `addr_step`, and an accepted write sets the dirty flag.
- R4: While `wp` is 1, writes give no `wr_ack` and no `addr_step`, the dirty flag is left unchanged, and the auto-store enable/disable commands are ignored. Reads are still accepted.
- R5: When `xreq_n` is sampled 0 while access is open, access closes on the next cycle. If the flag is dirty, `arr_store_go` pulses T_DELAY+1 cycles after the request is sampled.
- R6: A store request made while the flag is clean does not pulse `arr_store_go` and does not pull the line low. A clean software request leaves access open. A clean line request keeps access closed until `xreq_n` is 1, and access opens one cycle after that.
- R7: While a store runs, the line is pulled low (`bsy_oe`=1, `bsy_drv`=0), whichever source started it.
- R8: After a store started by the line or by software ends, the line is driven high (`bsy_oe`=1, `bsy_drv`=1) for exactly T_HIGH cycles and then released.
- R9: After that release, access stays closed for exactly T_GUARD cycles and then opens.
- R10: If `xreq_n` is still 0 when the store ends, the line is released and access stays closed until `xreq_n` returns to 1. The sequence of R8 and R9 then follows.
- R11: A software store command given while access is open and the flag is dirty pulses `arr_store_go` on the next cycle.
- R12: When `pwr_ok` falls while auto-store is enabled and the flag is dirty, access closes on the next cycle and a store starts. After it ends there is no drive-high pulse, and access stays closed until `pwr_ok` returns and a recall completes.
- R13: Auto-store is enabled after reset. `as_off` disables it, and a supply drop then starts no store. `as_on` enables it again.
- R14: The dirty flag is cleared when a store or recall completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply above threshold |
| xreq_n | input | 1 | External store request, active low (external driver of the shared line) |
| sw_store | input | 1 | Software store command, one-cycle pulse |
| as_off | input | 1 | Command: disable auto-store |
| as_on | input | 1 | Command: enable auto-store |
| wp | input | 1 | Write protect, active high |
| wr_req | input | 1 | SRAM write request from the bus side |
| rd_req | input | 1 | SRAM read request from the bus side |
| arr_done | input | 1 | Array finished the current store or recall (one-cycle strobe) |
| bsy_oe | output | 1 | Line driver enable (0 = released to pull-up) |
| bsy_drv | output | 1 | Level driven on the line when enabled |
| acc_open | output | 1 | Memory access allowed |
| wr_ack | output | 1 | Write accepted |
| rd_ack | output | 1 | Read accepted |
| addr_step | output | 1 | Advance the address counter |
| dirty | output | 1 | SRAM written since the last transfer |
| arr_store_go | output | 1 | Start a store in the array (pulse) |
| arr_recall_go | output | 1 | Start a recall in the array (pulse) |

## Verification
Stores are requested from each of the three sources, once with the dirty flag set and once with it clear. This shows whether the array is really started only for dirty data, and whether each source follows its own timing: the delay for the line, an immediate start for software, and no high pulse after a power-fail store. A line request that is still held low when the store finishes is kept apart from one that has already been released. This tells the hold behaviour apart from the plain drive-high and guard sequence, and the lengths of both of those phases are counted. A table of read and write requests with write protect on and off shows which accesses are acknowledged and which ones mark the data dirty. A disable command given under write protect, followed by a supply drop, shows that the command was ignored.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [3:0] {
    S_DOWN   = 4'd0,
    S_RECALL = 4'd1,
    S_IDLE   = 4'd2,
    S_DELAY  = 4'd3,
    S_STORE  = 4'd4,
    S_HOLD   = 4'd5,
    S_DRVHI  = 4'd6,
    S_GUARD  = 4'd7,
    S_WAITHI = 4'd8,
    S_PFST   = 4'd9
  } seq_state_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nvx_timer.sv
module nvx_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/nvx_gate.sv
module nvx_gate (
  input  logic clk,
  input  logic rst,
  input  logic acc_open,
  input  logic wp,
  input  logic wr_req,
  input  logic rd_req,
  input  logic as_off,
  input  logic as_on,
  input  logic xfer_done,
  output logic wr_ack,
  output logic rd_ack,
  output logic addr_step,
  output logic dirty,
  output logic as_en
);

  logic wr_ok;
  logic rd_ok;

  assign wr_ok = wr_req && acc_open && !wp;
  assign rd_ok = rd_req && acc_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ack    <= 1'b0;
      rd_ack    <= 1'b0;
      addr_step <= 1'b0;
      dirty     <= 1'b0;
      as_en     <= 1'b1;
    end else begin
      wr_ack    <= wr_ok;
      rd_ack    <= rd_ok;
      addr_step <= wr_ok || rd_ok;
      if (xfer_done) begin
        dirty <= 1'b0;
      end else if (wr_ok) begin
        dirty <= 1'b1;
      end
      if (!wp) begin
        if (as_off) begin
          as_en <= 1'b0;
        end else if (as_on) begin
          as_en <= 1'b1;
        end
      end
    end
  end

  // R4: a protected cycle never yields a write acknowledge
  a_r4_wp_no_write: assert property (@(posedge clk) disable iff (rst)
    wp |=> !wr_ack);

  // R3: no write acknowledge while access is closed
  a_r3_closed_no_ack: assert property (@(posedge clk) disable iff (rst)
    !acc_open |=> !wr_ack && !rd_ack);

endmodule

// File: rtl/nvx_fsm.sv
module nvx_fsm
  import nvx_pkg::*;
#(
  parameter int T_DELAY = 4,
  parameter int T_HIGH  = 2,
  parameter int T_GUARD = 3,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_ok,
  input  logic          xreq_n,
  input  logic          sw_store,
  input  logic          as_en,
  input  logic          dirty,
  input  logic          arr_done,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          xfer_done,
  output logic          st_go,
  output logic          rc_go,
  output logic          acc_open,
  output logic          bsy_oe,
  output logic          bsy_drv
);

  localparam logic [CW-1:0] LD_DELAY = CW'(T_DELAY - 1);
  localparam logic [CW-1:0] LD_HIGH  = CW'(T_HIGH - 1);
  localparam logic [CW-1:0] LD_GUARD = CW'(T_GUARD - 1);

  seq_state_t state_q, state_d;
  logic       pf_hit;
  logic       pf_target_store;

  // supply loss is honoured in every state that is not already transferring
  always_comb begin
    case (state_q)
      S_IDLE, S_DELAY, S_HOLD, S_DRVHI, S_GUARD, S_WAITHI: pf_hit = !pwr_ok;
      default:                                             pf_hit = 1'b0;
    endcase
  end

  assign pf_target_store = as_en && dirty;

  always_comb begin
    state_d = state_q;
    if (pf_hit) begin
      state_d = pf_target_store ? S_PFST : S_DOWN;
    end else begin
      case (state_q)
        S_DOWN:   if (pwr_ok) state_d = S_RECALL;
        S_RECALL: if (arr_done) state_d = pwr_ok ? S_IDLE : S_DOWN;
        S_IDLE: begin
          if (!xreq_n)                state_d = S_DELAY;
          else if (sw_store && dirty) state_d = S_STORE;
        end
        S_DELAY:  if (tmr_zero) state_d = dirty ? S_STORE : S_WAITHI;
        S_STORE: begin
          if (arr_done) begin
            if (!pwr_ok)      state_d = S_DOWN;
            else if (!xreq_n) state_d = S_HOLD;
            else              state_d = S_DRVHI;
          end
        end
        S_HOLD:   if (xreq_n) state_d = S_DRVHI;
        S_DRVHI:  if (tmr_zero) state_d = S_GUARD;
        S_GUARD:  if (tmr_zero) state_d = S_IDLE;
        S_WAITHI: if (xreq_n) state_d = S_IDLE;
        S_PFST:   if (arr_done) state_d = S_DOWN;
        default:  state_d = S_DOWN;
      endcase
    end
  end

  always_comb begin
    tmr_load = (state_d != state_q) &&
               (state_d == S_DELAY || state_d == S_DRVHI || state_d == S_GUARD);
    case (state_d)
      S_DELAY: tmr_val = LD_DELAY;
      S_DRVHI: tmr_val = LD_HIGH;
      default: tmr_val = LD_GUARD;
    endcase
  end

  assign xfer_done = arr_done &&
                     (state_q == S_STORE || state_q == S_PFST || state_q == S_RECALL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_DOWN;
      acc_open <= 1'b0;
      bsy_oe   <= 1'b0;
      bsy_drv  <= 1'b0;
      st_go    <= 1'b0;
      rc_go    <= 1'b0;
    end else begin
      state_q  <= state_d;
      acc_open <= (state_d == S_IDLE);
      bsy_oe   <= (state_d == S_STORE) || (state_d == S_PFST) || (state_d == S_DRVHI);
      bsy_drv  <= (state_d == S_DRVHI);
      st_go    <= (state_d != state_q) && (state_d == S_STORE || state_d == S_PFST);
      rc_go    <= (state_d != state_q) && (state_d == S_RECALL);
    end
  end

  // R12: a supply loss closes access on the following cycle
  a_r12_pf_closes: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !acc_open);

  // R2: a recall start is never paired with open access
  a_r2_recall_closed: assert property (@(posedge clk) disable iff (rst)
    rc_go |-> !acc_open);

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nvx_pkg::*;
#(
  parameter int T_DELAY = 4,
  parameter int T_HIGH  = 2,
  parameter int T_GUARD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic xreq_n,
  input  logic sw_store,
  input  logic as_off,
  input  logic as_on,
  input  logic wp,
  input  logic wr_req,
  input  logic rd_req,
  input  logic arr_done,
  output logic bsy_oe,
  output logic bsy_drv,
  output logic acc_open,
  output logic wr_ack,
  output logic rd_ack,
  output logic addr_step,
  output logic dirty,
  output logic arr_store_go,
  output logic arr_recall_go
);

  localparam int TMAX = max3(T_DELAY, T_HIGH, T_GUARD);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  logic          as_en;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          xfer_done;

  nvx_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  nvx_fsm #(
    .T_DELAY (T_DELAY),
    .T_HIGH  (T_HIGH),
    .T_GUARD (T_GUARD),
    .CW      (CW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pwr_ok    (pwr_ok),
    .xreq_n    (xreq_n),
    .sw_store  (sw_store),
    .as_en     (as_en),
    .dirty     (dirty),
    .arr_done  (arr_done),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .xfer_done (xfer_done),
    .st_go     (arr_store_go),
    .rc_go     (arr_recall_go),
    .acc_open  (acc_open),
    .bsy_oe    (bsy_oe),
    .bsy_drv   (bsy_drv)
  );

  nvx_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .acc_open  (acc_open),
    .wp        (wp),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .as_off    (as_off),
    .as_on     (as_on),
    .xfer_done (xfer_done),
    .wr_ack    (wr_ack),
    .rd_ack    (rd_ack),
    .addr_step (addr_step),
    .dirty     (dirty),
    .as_en     (as_en)
  );

  // R6: the array is only started on dirty data
  a_r6_store_needs_dirty: assert property (@(posedge clk) disable iff (rst)
    arr_store_go |-> dirty);

  // R5: a line request seen while open closes access next cycle
  a_r5_req_closes: assert property (@(posedge clk) disable iff (rst)
    (acc_open && !xreq_n) |=> !acc_open);

  // R9: access is still closed when the line is released
  a_r9_release_guarded: assert property (@(posedge clk) disable iff (rst)
    $fell(bsy_oe) |-> !acc_open);

  // R7: a pulled-low line never coexists with open access
  a_r7_low_closed: assert property (@(posedge clk) disable iff (rst)
    (bsy_oe && !bsy_drv) |-> !acc_open);

endmodule

// File: tb/nv_xfer_seq_tb.sv
module nv_xfer_seq_tb;

  localparam int T_DELAY = 4;
  localparam int T_HIGH  = 2;
  localparam int T_GUARD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0, xreq_n = 1'b1, sw_store = 1'b0, as_off = 1'b0, as_on = 1'b0;
  logic wp = 1'b0, wr_req = 1'b0, rd_req = 1'b0, arr_done = 1'b0;
  logic bsy_oe, bsy_drv, acc_open, wr_ack, rd_ack, addr_step, dirty;
  logic arr_store_go, arr_recall_go;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  nv_xfer_seq #(.T_DELAY(T_DELAY), .T_HIGH(T_HIGH), .T_GUARD(T_GUARD)) u_dut (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .xreq_n(xreq_n), .sw_store(sw_store),
    .as_off(as_off), .as_on(as_on), .wp(wp), .wr_req(wr_req), .rd_req(rd_req),
    .arr_done(arr_done), .bsy_oe(bsy_oe), .bsy_drv(bsy_drv), .acc_open(acc_open),
    .wr_ack(wr_ack), .rd_ack(rd_ack), .addr_step(addr_step), .dirty(dirty),
    .arr_store_go(arr_store_go), .arr_recall_go(arr_recall_go)
  );

  // {wp, wr, rd, exp_wr_ack, exp_rd_ack, exp_step, exp_dirty}
  localparam logic [6:0] VEC [6] = '{
    7'b1_1_0_0_0_0_0,
    7'b0_0_1_0_1_1_0,
    7'b1_0_1_0_1_1_0,
    7'b0_1_0_1_0_1_1,
    7'b1_1_0_0_0_0_1,
    7'b0_0_0_0_0_0_1
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_done();
    arr_done = 1'b1;
    tick();
    arr_done = 1'b0;
  endtask

  task automatic dirty_write();
    wr_req = 1'b1;
    tick();
    wr_req = 1'b0;
  endtask

  task automatic count_tail(input string tag);
    int n = 0;
    int g = 0;
    while (bsy_oe && bsy_drv && n < 50) begin n++; tick(); end
    chk(n == T_HIGH, {tag, " R8 drive-high cycles"}, n, T_HIGH);
    while (!bsy_oe && !acc_open && g < 50) begin g++; tick(); end
    chk(g == T_GUARD, {tag, " R9 guard cycles"}, g, T_GUARD);
    chk(acc_open == 1'b1, {tag, " R9 open after guard"}, acc_open, 1);
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(!acc_open && !bsy_oe && !dirty && !arr_recall_go && !arr_store_go,
        "R1 reset state", {acc_open, bsy_oe, dirty, arr_recall_go}, 0);

    // R2 power-up recall
    pwr_ok = 1'b1;
    tick();
    chk(arr_recall_go == 1'b1, "R2 recall pulse", arr_recall_go, 1);
    chk(acc_open == 1'b0, "R2 closed during recall", acc_open, 0);
    repeat (3) tick();
    chk(acc_open == 1'b0 && arr_recall_go == 1'b0, "R2 still closed", acc_open, 0);
    do_done();
    chk(acc_open == 1'b1, "R2 open after recall", acc_open, 1);

    // R3 / R4 access table
    foreach (VEC[i]) begin
      {wp, wr_req, rd_req} = VEC[i][6:4];
      tick();
      wp = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
      chk({wr_ack, rd_ack, addr_step, dirty} == VEC[i][3:0], "R3 R4 access vector",
          {wr_ack, rd_ack, addr_step, dirty}, VEC[i][3:0]);
    end

    // R11 software store with dirty data, R7 R8 R9 R14
    sw_store = 1'b1;
    tick();
    sw_store = 1'b0;
    chk(arr_store_go == 1'b1, "R11 sw store start", arr_store_go, 1);
    chk(bsy_oe && !bsy_drv, "R7 line low on sw store", {bsy_oe, bsy_drv}, 2);
    repeat (2) tick();
    chk(bsy_oe && !bsy_drv && !acc_open, "R7 line held low", {bsy_oe, bsy_drv}, 2);
    do_done();
    chk(dirty == 1'b0, "R14 dirty cleared by store", dirty, 0);
    count_tail("sw");

    // R6 clean software store
    sw_store = 1'b1;
    tick();
    sw_store = 1'b0;
    chk(!arr_store_go && acc_open && !bsy_oe, "R6 clean sw store ignored",
        {arr_store_go, acc_open, bsy_oe}, 2);

    // R5 line request with dirty data, R10 hold
    dirty_write();
    xreq_n = 1'b0;
    n = 0;
    seen = 1'b0;
    while (!seen && n < 30) begin
      tick();
      n++;
      if (n == 1) chk(acc_open == 1'b0, "R5 closes next cycle", acc_open, 0);
      seen = arr_store_go;
    end
    chk(n == T_DELAY + 1, "R5 store start delay", n, T_DELAY + 1);
    chk(bsy_oe && !bsy_drv, "R7 line low on line store", {bsy_oe, bsy_drv}, 2);
    do_done();
    repeat (3) begin
      chk(!bsy_oe && !acc_open, "R10 hold while request low", {bsy_oe, acc_open}, 0);
      tick();
    end
    xreq_n = 1'b1;
    tick();
    count_tail("hold");

    // R6 clean line request
    xreq_n = 1'b0;
    seen = 1'b0;
    repeat (T_DELAY + 3) begin
      tick();
      if (arr_store_go || bsy_oe) seen = 1'b1;
    end
    chk(!seen, "R6 clean line request no store", seen, 0);
    chk(acc_open == 1'b0, "R6 closed while request low", acc_open, 0);
    xreq_n = 1'b1;
    tick();
    chk(acc_open == 1'b1, "R6 opens after release", acc_open, 1);

    // R4 disable command under write protect ignored, then R12 power fail store
    wp = 1'b1; as_off = 1'b1;
    tick();
    wp = 1'b0; as_off = 1'b0;
    dirty_write();
    pwr_ok = 1'b0;
    tick();
    chk(arr_store_go == 1'b1, "R4 R12 pf store despite protected disable", arr_store_go, 1);
    chk(!acc_open && bsy_oe && !bsy_drv, "R12 R7 pf closes and line low",
        {acc_open, bsy_oe, bsy_drv}, 2);
    do_done();
    chk(!bsy_oe && !acc_open, "R12 no high pulse after pf store", {bsy_oe, acc_open}, 0);
    tick();
    chk(!acc_open && dirty == 1'b0, "R12 stays closed", {acc_open, dirty}, 0);
    pwr_ok = 1'b1;
    tick();
    chk(arr_recall_go == 1'b1, "R12 R2 recall on return", arr_recall_go, 1);
    do_done();
    chk(acc_open == 1'b1, "R12 open after recall", acc_open, 1);

    // R13 auto-store disabled, R14 recall clears dirty
    as_off = 1'b1;
    tick();
    as_off = 1'b0;
    dirty_write();
    pwr_ok = 1'b0;
    tick();
    chk(!arr_store_go && !acc_open && !bsy_oe, "R13 no store when disabled",
        {arr_store_go, acc_open, bsy_oe}, 0);
    tick();
    chk(dirty == 1'b1, "R13 dirty kept", dirty, 1);
    pwr_ok = 1'b1;
    tick();
    do_done();
    chk(dirty == 1'b0 && acc_open, "R14 recall clears dirty", {dirty, acc_open}, 1);
    as_on = 1'b1;
    tick();
    as_on = 1'b0;
    dirty_write();
    pwr_ok = 1'b0;
    tick();
    chk(arr_store_go == 1'b1, "R13 re-enabled pf store", arr_store_go, 1);
    do_done();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule